// File: doc/BRIEF.md
# Two-Bit Hysteresis Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a small table of 2-bit state entries, selected by a few low-order bits of the branch address. A lookup reads the entry for the address on the lookup port and returns a taken or not-taken prediction in the same cycle. When the pipeline later learns the real direction, it presents the branch address and the outcome on the resolve port. The entry then moves through a fixed four-state graph.

The graph is not a plain saturating counter. When a weak state mispredicts, the entry goes straight to the strong state of the opposite direction. Two mispredictions in a row are therefore enough to reverse the prediction. A strong state that mispredicts drops only to the weak state of its own direction. A resolve whose outcome differs from the entry's prediction before the update is a misprediction, and a free-running counter counts each one.

Top module: `hyst_branch_predictor`

## Requirements
- R1: After reset every entry is in state 00. Every lookup then predicts not-taken, and the misprediction count is 0.
- R2: The prediction is bit 1 of the entry state. States 00 and 01 predict not-taken (0), and states 10 and 11 predict taken (1).
- R3: From state 00, a taken outcome moves the entry to 01 and a not-taken outcome leaves it at 00.
- R4: From state 01, a taken outcome moves the entry directly to 11 and a not-taken outcome moves it to 00.
- R5: From state 11, a taken outcome leaves the entry at 11 and a not-taken outcome moves it to 10.
- R6: From state 10, a taken outcome moves the entry to 11 and a not-taken outcome moves it directly to 00.
- R7: Address bits [5:2] select one of the 16 entries. All other address bits are ignored, so addresses that differ only in those other bits share an entry, and an update to one entry leaves the other entries unchanged.
- R8: A lookup is combinational on the current table. If a lookup and a resolve hit the same entry in one cycle, the lookup returns the old prediction and the new state is seen from the next cycle on.
- R9: The 32-bit misprediction count rises by one in the cycle after a resolve whose outcome differs from the entry's pre-update prediction. It does not change otherwise.
- R10: While resolve_valid_i is low, no entry changes and the count does not change.
- R11: Starting from reset, a branch that resolves taken 999 times and then not-taken once produces exactly 3 mispredictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_pc_i | input | 32 | Address of the branch being predicted |
| lookup_taken_o | output | 1 | Prediction: 1 = taken, 0 = not-taken |
| resolve_valid_i | input | 1 | A resolved branch is presented this cycle |
| resolve_pc_i | input | 32 | Address of the resolved branch |
| resolve_taken_i | input | 1 | Actual outcome: 1 = taken |
| miss_count_o | output | 32 | Number of mispredictions since reset |

## Verification
The ports never show an entry's state, only its top bit. The hardest case is telling state 00 from state 01, and state 10 from state 11. Directed sequences on a single entry drive it into each state. A further resolve then makes the states diverge: from 00 or 01 a taken outcome gives different next predictions, and from 10 or 11 a not-taken outcome does. Random resolves spread over aliased addresses, together with same-cycle lookups of the entry being resolved, cover how entries and the counter interact.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  // bit 1 is the predicted direction
  typedef enum logic [1:0] {
    HB_NT_FIRM = 2'b00,
    HB_NT_SOFT = 2'b01,
    HB_T_SOFT  = 2'b10,
    HB_T_FIRM  = 2'b11
  } hb_state_e;

  function automatic logic hb_predict(hb_state_e s);
    return s[1];
  endfunction

  function automatic hb_state_e hb_next(hb_state_e s, logic taken);
    hb_state_e n;
    unique case (s)
      HB_NT_FIRM: n = taken ? HB_NT_SOFT : HB_NT_FIRM;
      HB_NT_SOFT: n = taken ? HB_T_FIRM  : HB_NT_FIRM;
      HB_T_FIRM:  n = taken ? HB_T_FIRM  : HB_T_SOFT;
      default:    n = taken ? HB_T_FIRM  : HB_NT_FIRM;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/hbp_index.sv
module hbp_index #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int IDX_LSB = 2
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  logic unused_pc_bits;
  assign unused_pc_bits = ^pc_i;
  assign idx_o = pc_i[IDX_LSB +: IDX_W];
endmodule

// File: rtl/hbp_table.sv
module hbp_table
  import hbp_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i,
  output logic             wr_old_taken_o
);

  hb_state_e [ENTRIES-1:0] table_q;
  hb_state_e               wr_next;

  always_comb wr_next = hb_next(table_q[wr_idx_i], wr_taken_i);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   table_q[g] <= HB_NT_FIRM;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     table_q[g] <= wr_next;
    end
  end

  assign rd_taken_o     = hb_predict(table_q[rd_idx_i]);
  assign wr_old_taken_o = hb_predict(table_q[wr_idx_i]);

  // R3
  nt_firm_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && table_q[wr_idx_i] == HB_NT_FIRM |=>
      table_q[$past(wr_idx_i)] == ($past(wr_taken_i) ? HB_NT_SOFT : HB_NT_FIRM));

  // R4
  nt_soft_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && table_q[wr_idx_i] == HB_NT_SOFT |=>
      table_q[$past(wr_idx_i)] == ($past(wr_taken_i) ? HB_T_FIRM : HB_NT_FIRM));

  // R5
  t_firm_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && table_q[wr_idx_i] == HB_T_FIRM |=>
      table_q[$past(wr_idx_i)] == ($past(wr_taken_i) ? HB_T_FIRM : HB_T_SOFT));

  // R6
  t_soft_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && table_q[wr_idx_i] == HB_T_SOFT |=>
      table_q[$past(wr_idx_i)] == ($past(wr_taken_i) ? HB_T_FIRM : HB_NT_FIRM));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(table_q));

endmodule

// File: rtl/hbp_miss_ctr.sv
module hbp_miss_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R9
  miss_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R9
  miss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/hyst_branch_predictor.sv
module hyst_branch_predictor #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_LSB = 2,
  parameter int CNT_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  lookup_pc_i,
  output logic             lookup_taken_o,
  input  logic             resolve_valid_i,
  input  logic [PC_W-1:0]  resolve_pc_i,
  input  logic             resolve_taken_i,
  output logic [CNT_W-1:0] miss_count_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic             rs_old_taken;
  logic             miss;

  hbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_lk_idx (
    .pc_i(lookup_pc_i), .idx_o(lk_idx));

  hbp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_rs_idx (
    .pc_i(resolve_pc_i), .idx_o(rs_idx));

  hbp_table #(.ENTRIES(ENTRIES)) u_table (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rd_idx_i       (lk_idx),
    .rd_taken_o     (lookup_taken_o),
    .wr_en_i        (resolve_valid_i),
    .wr_idx_i       (rs_idx),
    .wr_taken_i     (resolve_taken_i),
    .wr_old_taken_o (rs_old_taken)
  );

  assign miss = resolve_valid_i && (resolve_taken_i != rs_old_taken);

  hbp_miss_ctr #(.CNT_W(CNT_W)) u_miss (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(miss), .cnt_o(miss_count_o));

  // R8
  same_entry_old_pred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resolve_valid_i && lk_idx == rs_idx |-> lookup_taken_o == rs_old_taken);

  // R10
  idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resolve_valid_i |=> $stable(miss_count_o));
endmodule

// File: tb/hyst_branch_predictor_test.sv
module hyst_branch_predictor_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lookup_pc = '0;
  logic        lookup_taken;
  logic        rv = 1'b0;
  logic [31:0] rpc = '0;
  logic        rtaken = 1'b0;
  logic [31:0] miss_count;

  int checks = 0;
  int fails  = 0;
  logic [1:0]  m_st [16];
  logic [31:0] m_cnt;

  always #2 clk = ~clk;

  hyst_branch_predictor uut (
    .clk_i(clk), .rst_ni(rst_ni), .lookup_pc_i(lookup_pc),
    .lookup_taken_o(lookup_taken), .resolve_valid_i(rv),
    .resolve_pc_i(rpc), .resolve_taken_i(rtaken), .miss_count_o(miss_count));

  function automatic logic [1:0] exp_next(logic [1:0] s, logic t);
    case (s)
      2'b00: return t ? 2'b01 : 2'b00;
      2'b01: return t ? 2'b11 : 2'b00;
      2'b11: return t ? 2'b11 : 2'b10;
      default: return t ? 2'b11 : 2'b00;
    endcase
  endfunction

  function automatic logic [3:0] ix(logic [31:0] pc);
    return pc[5:2];
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; rv = 1'b0;
    foreach (m_st[i]) m_st[i] = 2'b00;
    m_cnt = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // one cycle: lookup checked against model before the edge, model updated after
  task automatic step(string tag, logic [31:0] lpc, logic v, logic [31:0] pc, logic t);
    @(negedge clk);
    lookup_pc = lpc; rv = v; rpc = pc; rtaken = t;
    #1;
    chk(tag, {31'd0, lookup_taken}, {31'd0, m_st[ix(lpc)][1]}, "prediction");
    chk(tag, miss_count, m_cnt, "miss count");
    if (v) begin
      if (t != m_st[ix(pc)][1]) m_cnt++;
      m_st[ix(pc)] = exp_next(m_st[ix(pc)], t);
    end
  endtask

  initial begin
    #300000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] base;
    do_reset();
    // R1: all entries not-taken, count zero
    for (int i = 0; i < 16; i++) step("R1", 32'(i) << 2, 1'b0, '0, 1'b0);

    // R3 R4 R5 R6 R2: walk entry 3, lookup same entry (R8 old value)
    step("R3", 32'h0C, 1'b1, 32'h0C, 1'b0);  // 00 -> 00
    step("R3", 32'h0C, 1'b1, 32'h0C, 1'b1);  // 00 -> 01
    step("R4", 32'h0C, 1'b1, 32'h0C, 1'b0);  // 01 -> 00
    step("R3", 32'h0C, 1'b1, 32'h0C, 1'b1);  // 00 -> 01
    step("R4", 32'h0C, 1'b1, 32'h0C, 1'b1);  // 01 -> 11
    step("R5", 32'h0C, 1'b1, 32'h0C, 1'b1);  // 11 -> 11
    step("R5", 32'h0C, 1'b1, 32'h0C, 1'b0);  // 11 -> 10
    step("R6", 32'h0C, 1'b1, 32'h0C, 1'b1);  // 10 -> 11
    step("R5", 32'h0C, 1'b1, 32'h0C, 1'b0);  // 11 -> 10
    step("R6", 32'h0C, 1'b1, 32'h0C, 1'b0);  // 10 -> 00
    step("R2", 32'h0C, 1'b0, 32'h0C, 1'b0);
    step("R8", 32'h0C, 1'b1, 32'h0C, 1'b1);  // old NT returned
    step("R8", 32'h0C, 1'b0, '0, 1'b0);       // now 01, still NT

    // R10: idle resolve inputs must not disturb state or count
    for (int i = 0; i < 6; i++) step("R10", 32'h0C, 1'b0, 32'h0C, 1'b1);
    step("R10", 32'h0C, 1'b1, 32'h0C, 1'b1);  // 01 -> 11 proves entry was kept

    // R7: aliasing via upper and low bits, neighbours untouched
    step("R7", 32'hFFFF_FF17, 1'b1, 32'h0000_1014, 1'b1);
    step("R7", 32'h0000_0014, 1'b1, 32'hABCD_0016, 1'b1);
    step("R7", 32'h8000_0017, 1'b0, '0, 1'b0);
    step("R7", 32'h0000_0018, 1'b0, '0, 1'b0);
    step("R7", 32'h0000_0010, 1'b0, '0, 1'b0);

    // R9: random resolves with random lookups
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      a = $urandom(n == 0 ? 32'd77 : 32'd0);
      b = $urandom();
      if (n % 4 == 0) a = b;
      step("R9", a, ($urandom() % 4) != 0, b, $urandom() % 3 != 0);
    end

    // R11: loop branch from reset
    do_reset();
    base = m_cnt;
    for (int n = 0; n < 1000; n++) step("R11", 32'h0000_2040, 1'b1, 32'h0000_2040, n < 999);
    step("R11", 32'h0000_2040, 1'b0, '0, 1'b0);
    chk("R11", miss_count - base, 32'd3, "loop mispredictions");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule